// File: doc/BRIEF.md
# Supervisory reset pulse generator

This block turns two fault sources into one clean processor reset. One source is a digital supply-good flag from an external threshold comparator. It is high while the rail is above the reset threshold. The other source is an active-low manual reset request, which may come from a push switch or from another logic output, such as a watchdog output routed back in.

Reset is held for as long as either source reports a fault. After both sources clear, reset is stretched by a fixed hold interval of `HOLD_CYCLES` clocks. The default is 20,000,000 clocks, which is 200 ms at 100 MHz. Any new fault during the stretch throws the count away. The next full interval then starts only after the fault clears again. This same stretch absorbs switch bounce, so no separate debounce filter is used.

Both inputs are asynchronous to the clock and pass through a two-flop synchronizer each. The block drives an active-low reset and its active-high complement. A watchdog timeout has no path of its own into this block: it causes a reset only when it is wired to the manual input.

Top module: `sup_reset_gen`

## Requirements
- R1: While `arst_n` is low and on the first clock after it is released, `rst_out_n` is 0 and `rst_out` is 1.
- R2: While `supply_ok` is 0, reset stays asserted. A fall of `supply_ok` shows on the outputs no later than the third rising edge after the change.
- R3: A low level on `man_rst_n` asserts reset. A low level held across a single rising edge is enough, with the same three-edge latency as R2.
- R4: Suppose both inputs become inactive and stay inactive. Count the first rising edge after the last change as edge 1. Then `rst_out_n` rises on edge `HOLD_CYCLES`+3: two synchronizer edges, one edge to enter the hold, and `HOLD_CYCLES` counted edges.
- R5: A fault on either input while the hold is running cancels the hold. Release then follows the full R4 timing, measured from the moment that fault clears.
- R6: A burst of bounces on `man_rst_n`, each shorter than the hold, produces one unbroken reset pulse. That pulse ends by the R4 timing, measured from the last rising edge of the burst.
- R7: When the two sources overlap, release follows the R4 timing from the later of the two clears.
- R8: `rst_out` is at every clock the exact inverse of `rst_out_n`.
- R9: The internal hold count never reaches `HOLD_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low block reset (power-on), released synchronously upstream |
| supply_ok | input | 1 | 1 = supply above threshold, 0 = below (asynchronous) |
| man_rst_n | input | 1 | Active-low manual reset request (asynchronous, may bounce) |
| rst_out_n | output | 1 | Active-low processor reset |
| rst_out | output | 1 | Active-high processor reset, inverse of `rst_out_n` |

## Verification
The hardest case to reach is a fault that arrives in the last few counts of a hold, just before release. It must restart the interval, not shorten or merge with it. The stimulus releases a source and then waits a measured number of cycles, chosen so that a one-cycle supply dip lands inside the final counts of the hold. Bounce bursts with gaps of one and two cycles then exercise the restart many times in a row. A reference model checks the exact release edge after every restart.

// File: rtl/srg_pkg.sv
package srg_pkg;
  typedef enum logic [1:0] {
    ST_FAULT = 2'd0,
    ST_HOLD  = 2'd1,
    ST_RUN   = 2'd2
  } srg_state_e;
endpackage

// File: rtl/srg_sync.sv
module srg_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = d;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= {STAGES{RESET_VAL}};
    else         chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/srg_hold_timer.sv
module srg_hold_timer #(
  parameter int HOLD_CYCLES = 20_000_000,
  localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign done = en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (done) cnt_d = '0;
    else if (en)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R9: the count stays below the interval length
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q <= LAST);

  // R5: a clear always leaves the count at zero on the next cycle
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!arst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
  import srg_pkg::*;
#(
  parameter int HOLD_CYCLES = 20_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic supply_ok,
  input  logic man_rst_n,
  output logic rst_out_n,
  output logic rst_out
);
  logic supply_ok_s;
  logic man_rst_n_s;
  logic fault;
  logic tmr_clr;
  logic tmr_en;
  logic tmr_done;
  srg_state_e state_q;
  srg_state_e state_d;

  // Both sources reset to their fault level, so power-on starts in reset.
  srg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sup (
    .clk(clk), .arst_n(arst_n), .d(supply_ok), .q(supply_ok_s));

  srg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_man (
    .clk(clk), .arst_n(arst_n), .d(man_rst_n), .q(man_rst_n_s));

  assign fault = !supply_ok_s || !man_rst_n_s;

  assign tmr_clr = (state_q != ST_HOLD) || fault;
  assign tmr_en  = (state_q == ST_HOLD) && !fault;

  srg_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk(clk), .arst_n(arst_n), .clr(tmr_clr), .en(tmr_en), .done(tmr_done));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FAULT: if (!fault) state_d = ST_HOLD;
      ST_HOLD: begin
        if (fault)         state_d = ST_FAULT;
        else if (tmr_done) state_d = ST_RUN;
      end
      ST_RUN:   if (fault) state_d = ST_FAULT;
      default:  state_d = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state_q <= ST_FAULT;
    else         state_q <= state_d;
  end

  assign rst_out_n = (state_q == ST_RUN);
  assign rst_out   = !rst_out_n;

  // R2: a low supply flag forces reset on the following cycle
  p_supply_forces_r2: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_ok_s |=> !rst_out_n);

  // R3: a synchronized manual request forces reset on the following cycle
  p_manual_forces_r3: assert property (@(posedge clk) disable iff (!arst_n)
    !man_rst_n_s |=> !rst_out_n);

  // R4: release only comes from a completed hold with no fault
  p_release_after_hold_r4: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_out_n) |-> ($past(tmr_done) && !$past(fault)));

  // R8: the two outputs are always complementary
  p_outputs_inverse_r8: assert property (@(posedge clk) disable iff (!arst_n)
    rst_out != rst_out_n);
endmodule

// File: tb/tb_sup_reset_gen.sv
module tb_sup_reset_gen;
  localparam int H = 20;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic man_rst_n = 1'b1;
  logic rst_out_n;
  logic rst_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string req = "R1";

  // reference model state
  bit m_s1 = 1'b1;
  bit m_s2 = 1'b1;
  int m_quiet = 0;
  bit exp_rst_n;

  always #5 clk = ~clk;

  sup_reset_gen #(.HOLD_CYCLES(H), .SYNC_STAGES(2)) dut (
    .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok),
    .man_rst_n(man_rst_n), .rst_out_n(rst_out_n), .rst_out(rst_out));

  // Behavioural model: faults arrive two edges late; reset lifts once
  // more than H consecutive quiet edges have been seen.
  always @(posedge clk) begin
    cycles++;
    if (!arst_n) begin
      m_s1 = 1'b1; m_s2 = 1'b1; m_quiet = 0;
    end else begin
      if (m_s2) m_quiet = 0;
      else if (m_quiet <= H) m_quiet++;
      m_s2 = m_s1;
      m_s1 = !supply_ok || !man_rst_n;
    end
  end

  always @(negedge clk) begin
    exp_rst_n = (m_quiet > H);
    checks++;
    if (rst_out_n !== exp_rst_n) begin
      errors++;
      $display("FAIL %s cycle %0d rst_out_n act=%b exp=%b", req, cycles, rst_out_n, exp_rst_n);
    end
    checks++;
    if (rst_out !== !exp_rst_n) begin
      errors++;
      $display("FAIL R8 cycle %0d rst_out act=%b exp=%b", cycles, rst_out, !exp_rst_n);
    end
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog act=%0d cycles exp<%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    // R1: reset state during and right after block reset
    req = "R1";
    wait_cyc(3);
    checks++;
    if (rst_out_n !== 1'b0 || rst_out !== 1'b1) begin
      errors++;
      $display("FAIL R1 act=%b%b exp=01", rst_out_n, rst_out);
    end
    arst_n = 1'b1;
    // R2: supply low keeps reset asserted
    req = "R2";
    wait_cyc(10);
    supply_ok = 1'b1;
    // R4: exact release edge
    req = "R4";
    wait_cyc(H + 8);
    // R3: manual request, single-cycle glitch
    req = "R3";
    man_rst_n = 1'b0; wait_cyc(1); man_rst_n = 1'b1;
    wait_cyc(H + 8);
    // R3 longer press
    man_rst_n = 1'b0; wait_cyc(6); man_rst_n = 1'b1;
    wait_cyc(H + 8);
    // R2: supply dip from run
    req = "R2";
    supply_ok = 1'b0; wait_cyc(4); supply_ok = 1'b1;
    // R5: dip near the end of the hold restarts it
    req = "R5";
    wait_cyc(H);
    supply_ok = 1'b0; wait_cyc(1); supply_ok = 1'b1;
    wait_cyc(H - 2);
    man_rst_n = 1'b0; wait_cyc(1); man_rst_n = 1'b1;
    wait_cyc(H + 8);
    // R6: bounce burst on manual input
    req = "R6";
    for (int k = 0; k < 6; k++) begin
      man_rst_n = 1'b0; wait_cyc(1 + (k % 2));
      man_rst_n = 1'b1; wait_cyc(2 + (k % 3));
    end
    wait_cyc(H + 8);
    // R7: overlapping sources, supply clears last
    req = "R7";
    man_rst_n = 1'b0; wait_cyc(3);
    supply_ok = 1'b0; wait_cyc(3);
    man_rst_n = 1'b1; wait_cyc(7);
    supply_ok = 1'b1;
    wait_cyc(H + 8);
    // R7: manual clears last
    supply_ok = 1'b0; wait_cyc(2);
    man_rst_n = 1'b0; wait_cyc(2);
    supply_ok = 1'b1; wait_cyc(9);
    man_rst_n = 1'b1;
    wait_cyc(H + 8);
    // R1: block reset in mid-run returns to asserted state
    req = "R1";
    arst_n = 1'b0; wait_cyc(2);
    arst_n = 1'b1;
    req = "R4";
    wait_cyc(H + 8);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule